// File: doc/BRIEF.md
# Streaming Trace Data Compressor

This block shrinks a stream of 8-bit trace samples on chip so that more trace history fits in a given amount of memory. While the enable input is high it takes one sample on every clock. For each sample it picks one of four encodings. A value that repeats the previous one extends a run of repeats. A change equal to the previous change extends a run of constant steps. A change that fits in five signed bits becomes a short delta. Anything else is passed through whole.

Each output packet is a 2-bit code and an 8-bit payload, marked by a save strobe. Downstream storage records the code and payload only on cycles where save is high. While a run is growing, nothing is emitted. The run is reported, with its count, when a sample breaks the pattern or when the count reaches its ceiling. A sample that breaks a run cannot share its cycle with the run report, so it waits in a one-entry holding slot and comes out on the following cycle. When enable falls, the block uses the next cycle to emit a held sample or an open run, then forgets all history.

Top module: `trcCompress`

## Requirements
- R1: The first sample taken after enable rises, or after reset, is emitted on the next cycle as a raw packet (code 2'b11) with the sample as payload. It is never compared against older history.
- R2: When the sample minus the previous sample, taken modulo 256, lies in -16..+15 and no run applies, the packet has code 2'b10. The payload holds that difference as 5-bit two's complement in bits 4:0, and bits 7:5 are zero.
- R3: When the difference lies outside -16..+15 and no run applies, the packet has code 2'b11 and carries the sample unchanged.
- R4: A sample equal to its predecessor emits nothing (save low). When the repeats end, the block emits one packet with code 2'b00 whose payload is the number of repeated samples. For example, 9,9,9,9 then 5 gives raw 9, then a 2'b00 packet with count 3, then the packet for 5.
- R5: A sample whose difference equals the previous difference (and is not a repeat) emits nothing. When that stops, the block emits one packet with code 2'b01 whose payload is the number of such samples. For example, 1,2,3,4 then 20 gives raw 1, small delta +1, a 2'b01 packet with count 2, then the packet for 20.
- R6: Packets come out in sample order. A sample that needs no holding is emitted one cycle after it is taken. A sample that breaks a run is emitted on the cycle after the run packet.
- R7: When a run's count reaches 255, the block emits a run packet with payload 255 at once. Counting then restarts from zero, and the next matching sample counts as 1 of a new run of the same kind.
- R8: On the first cycle after enable is seen low, the block emits the held sample or, if there is none, the open run packet. After the second such cycle, save stays low while enable stays low.
- R9: A synchronous active-high reset drives save low on the next cycle and clears all sample history, run counts and the holding slot.
- R10: The block tests a sample for a repeat first, then for a constant-step run, then for a short delta, then falls back to raw. A repeat that interrupts a constant-step run closes that run and opens a repeat run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | High while samples are being taken |
| sampleIn | input | 8 | Trace sample |
| save | output | 1 | High when the packet on this cycle must be stored |
| pktCode | output | 2 | Packet code: 00 repeat run, 01 step run, 10 short delta, 11 raw |
| payload | output | 8 | Run count, delta or raw sample |

## Verification
The bound checker watches, on every cycle, the properties that hold whatever the data: save low after reset, zero upper bits in short-delta packets, nonzero counts in run packets, a raw packet right after enable rises, and silence once enable has been low for two cycles. Exact run counts, the choice between encodings, the ordering through the holding slot, the 255 roll-over and the priority of repeats over steps depend on the sample history. Only the bench's reference model can show these, by comparing every output cycle during directed sequences and a long random stream with enable dropouts.

// File: rtl/trcPkg.sv
package trcPkg;

  typedef enum logic [1:0] {
    PK_REP   = 2'b00,
    PK_DRUN  = 2'b01,
    PK_SMALL = 2'b10,
    PK_RAW   = 2'b11
  } pktCode_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_RUN,
    SEL_SAMPLE
  } outSel_e;

  typedef enum logic [1:0] {
    RM_NONE,
    RM_REP,
    RM_DELTA
  } runMode_e;

  typedef struct packed {
    outSel_e  outSel;
    logic     pendLoad;
    logic     histLoad;
    logic     histClear;
    pktCode_e runCode;
  } ctrlStrobe_t;

  typedef struct packed {
    logic isRepeat;
    logic isDeltaRun;
  } dpFlags_t;

endpackage

// File: rtl/trcDatapath.sv
module trcDatapath
  import trcPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SMALL_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sampleIn,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] runCount,
  output dpFlags_t          flags,
  output logic              save,
  output logic [1:0]        pktCode,
  output logic [DATA_W-1:0] payload
);

  localparam int SMALL_MIN = -(1 << (SMALL_W - 1));
  localparam int SMALL_MAX = (1 << (SMALL_W - 1)) - 1;

  logic [DATA_W-1:0] prevSample, prevDelta, pendPay;
  logic              havePrev, haveDelta;
  pktCode_e          pendCode;

  logic [DATA_W-1:0] diff;
  logic              fitsSmall;
  pktCode_e          sampleCode;
  logic [DATA_W-1:0] samplePay;

  assign diff = sampleIn - prevSample;

  always_comb begin
    fitsSmall = havePrev
             && ($signed(diff) >= SMALL_MIN)
             && ($signed(diff) <= SMALL_MAX);
    flags.isRepeat   = havePrev && (sampleIn == prevSample);
    flags.isDeltaRun = haveDelta && (diff == prevDelta);
    if (fitsSmall) begin
      sampleCode = PK_SMALL;
      samplePay  = '0;
      samplePay[SMALL_W-1:0] = diff[SMALL_W-1:0];
    end else begin
      sampleCode = PK_RAW;
      samplePay  = sampleIn;
    end
  end

  // sample history
  always_ff @(posedge clk) begin
    if (rst || strobe.histClear) begin
      havePrev   <= 1'b0;
      haveDelta  <= 1'b0;
      prevSample <= '0;
      prevDelta  <= '0;
    end else if (strobe.histLoad) begin
      prevSample <= sampleIn;
      havePrev   <= 1'b1;
      if (havePrev) begin
        prevDelta <= diff;
        haveDelta <= 1'b1;
      end
    end
  end

  // holding slot and output register
  always_ff @(posedge clk) begin
    if (rst) begin
      pendCode <= PK_RAW;
      pendPay  <= '0;
      save     <= 1'b0;
      pktCode  <= 2'b00;
      payload  <= '0;
    end else begin
      if (strobe.pendLoad) begin
        pendCode <= sampleCode;
        pendPay  <= samplePay;
      end
      unique case (strobe.outSel)
        SEL_PEND: begin
          save    <= 1'b1;
          pktCode <= pendCode;
          payload <= pendPay;
        end
        SEL_RUN: begin
          save    <= 1'b1;
          pktCode <= strobe.runCode;
          payload <= runCount;
        end
        SEL_SAMPLE: begin
          save    <= 1'b1;
          pktCode <= sampleCode;
          payload <= samplePay;
        end
        default: begin
          save    <= 1'b0;
          pktCode <= 2'b00;
          payload <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/trcControl.sv
module trcControl
  import trcPkg::*;
#(
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  dpFlags_t         flags,
  output ctrlStrobe_t      strobe,
  output logic [RUN_W-1:0] runCount
);

  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  runMode_e         mode, modeNext, wantMode;
  logic [RUN_W-1:0] count, countNext, bumped;
  logic             pendValid, pendNext;
  logic             runEmit, sampleEmit;
  pktCode_e         oldRunCode;

  assign bumped     = count + 1'b1;
  assign oldRunCode = (mode == RM_DELTA) ? PK_DRUN : PK_REP;
  assign wantMode   = flags.isRepeat ? RM_REP : RM_DELTA;

  always_comb begin
    strobe     = '{outSel: SEL_NONE, pendLoad: 1'b0, histLoad: 1'b0,
                   histClear: 1'b0, runCode: PK_REP};
    runCount   = '0;
    modeNext   = mode;
    countNext  = count;
    runEmit    = 1'b0;
    sampleEmit = 1'b0;
    if (enable) begin
      strobe.histLoad = 1'b1;
      if (flags.isRepeat || flags.isDeltaRun) begin
        if (mode == wantMode) begin
          if (bumped == RUN_MAX) begin
            runEmit        = 1'b1;
            strobe.runCode = oldRunCode;
            runCount       = bumped;
            countNext      = '0;
          end else begin
            countNext = bumped;
          end
        end else begin
          if (count != '0) begin
            runEmit        = 1'b1;
            strobe.runCode = oldRunCode;
            runCount       = count;
          end
          modeNext  = wantMode;
          countNext = 1;
        end
      end else begin
        sampleEmit = 1'b1;
        if (count != '0) begin
          runEmit        = 1'b1;
          strobe.runCode = oldRunCode;
          runCount       = count;
        end
        modeNext  = RM_NONE;
        countNext = '0;
      end
      if (pendValid) begin
        strobe.outSel   = SEL_PEND;
        strobe.pendLoad = sampleEmit;
      end else if (runEmit) begin
        strobe.outSel   = SEL_RUN;
        strobe.pendLoad = sampleEmit;
      end else if (sampleEmit) begin
        strobe.outSel = SEL_SAMPLE;
      end
    end else begin
      strobe.histClear = 1'b1;
      if (pendValid) begin
        strobe.outSel = SEL_PEND;
      end else if (count != '0) begin
        strobe.outSel  = SEL_RUN;
        strobe.runCode = oldRunCode;
        runCount       = count;
      end
      modeNext  = RM_NONE;
      countNext = '0;
    end
    pendNext = strobe.pendLoad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= RM_NONE;
      count     <= '0;
      pendValid <= 1'b0;
    end else begin
      mode      <= modeNext;
      count     <= countNext;
      pendValid <= pendNext;
    end
  end

endmodule

// File: rtl/trcCompress.sv
module trcCompress
  import trcPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SMALL_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              save,
  output logic [1:0]        pktCode,
  output logic [DATA_W-1:0] payload
);

  ctrlStrobe_t       strobe;
  dpFlags_t          flags;
  logic [DATA_W-1:0] runCount;

  trcControl #(.RUN_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .flags    (flags),
    .strobe   (strobe),
    .runCount (runCount)
  );

  trcDatapath #(.DATA_W(DATA_W), .SMALL_W(SMALL_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .sampleIn (sampleIn),
    .strobe   (strobe),
    .runCount (runCount),
    .flags    (flags),
    .save     (save),
    .pktCode  (pktCode),
    .payload  (payload)
  );

endmodule

// File: rtl/trcCompressChk.sv
module trcCompressChk #(
  parameter int DATA_W  = 8,
  parameter int SMALL_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [DATA_W-1:0] sampleIn,
  input logic              save,
  input logic [1:0]        pktCode,
  input logic [DATA_W-1:0] payload
);

  // R9
  reset_clear_chk: assert property (@(posedge clk) rst |=> !save);

  // R2
  small_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (save && pktCode == 2'b10) |-> (payload[DATA_W-1:SMALL_W] == '0));

  // R4 R5
  run_count_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (save && !pktCode[1]) |-> (payload != '0));

  // R1
  first_raw_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(enable) |=> (save && pktCode == 2'b11 && payload == $past(sampleIn)));

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable ##1 !enable) |=> !save);

endmodule

bind trcCompress trcCompressChk #(.DATA_W(DATA_W), .SMALL_W(SMALL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .sampleIn (sampleIn),
  .save     (save),
  .pktCode  (pktCode),
  .payload  (payload)
);

// File: tb/trcCompress_tb.sv
module trcCompress_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [7:0] sampleIn = 8'd0;
  logic       save;
  logic [1:0] pktCode;
  logic [7:0] payload;

  int    total = 0;
  int    bad = 0;
  string curReq = "R9";

  // reference model state
  int mPrev, mDelta, mMode, mCnt;
  bit mHavePrev, mHaveDelta;
  int mQ[$];
  bit expSave;
  int expCode, expPay;

  always #10 clk = ~clk;

  trcCompress u_dut (
    .clk(clk), .rst(rst), .enable(enable), .sampleIn(sampleIn),
    .save(save), .pktCode(pktCode), .payload(payload)
  );

  task automatic modelClear();
    mHavePrev = 0; mHaveDelta = 0; mPrev = 0; mDelta = 0;
    mMode = 0; mCnt = 0; mQ.delete();
  endtask

  function automatic int runPkt(int mode, int cnt);
    return ((mode == 2) ? 256 : 0) + cnt;
  endfunction

  task automatic modelStep(bit r, bit en, int d);
    int diff, sd, want, pkt;
    if (r) begin
      modelClear();
      expSave = 0;
      return;
    end
    if (!en) begin
      if (mQ.size() == 0 && mCnt > 0) mQ.push_back(runPkt(mMode, mCnt));
    end else begin
      diff = (d - mPrev) & 255;
      sd = (diff >= 128) ? diff - 256 : diff;
      want = 0;
      if (mHavePrev && d == mPrev) want = 1;
      else if (mHaveDelta && diff == mDelta) want = 2;
      if (want != 0) begin
        if (mMode == want) begin
          mCnt++;
          if (mCnt == 255) begin
            mQ.push_back(runPkt(mMode, 255));
            mCnt = 0;
          end
        end else begin
          if (mCnt > 0) mQ.push_back(runPkt(mMode, mCnt));
          mMode = want;
          mCnt = 1;
        end
      end else begin
        if (mCnt > 0) mQ.push_back(runPkt(mMode, mCnt));
        mMode = 0; mCnt = 0;
        if (mHavePrev && sd >= -16 && sd <= 15) mQ.push_back(2 * 256 + (sd & 31));
        else mQ.push_back(3 * 256 + d);
      end
      if (mHavePrev) begin mDelta = diff; mHaveDelta = 1; end
      mPrev = d; mHavePrev = 1;
    end
    if (mQ.size() > 0) begin
      pkt = mQ.pop_front();
      expSave = 1; expCode = pkt / 256; expPay = pkt % 256;
    end else begin
      expSave = 0;
    end
    if (!en) modelClear();
  endtask

  task automatic checkOut();
    total++;
    if (save !== expSave ||
        (expSave && (pktCode !== expCode[1:0] || payload !== expPay[7:0]))) begin
      bad++;
      $display("FAIL %s: got save=%0b code=%0d payload=%0d expected save=%0b code=%0d payload=%0d",
               curReq, save, pktCode, payload, expSave, expCode, expPay);
    end
  endtask

  // compare the output of the last edge, then drive and predict the next
  task automatic step(bit r, bit en, int d);
    @(negedge clk);
    checkOut();
    rst = r; enable = en; sampleIn = d[7:0];
    modelStep(r, en, d);
  endtask

  task automatic feed(int d);
    step(0, 1, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cur, dl, sel;
    modelClear();
    expSave = 0; expCode = 0; expPay = 0;
    // R9: reset state
    curReq = "R9";
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    idle(2);

    // R1: first sample raw; R3 large changes raw
    curReq = "R1";
    feed(77);
    curReq = "R3";
    feed(200); feed(17); feed(0); feed(128);
    idle(3);

    // R2: small deltas including extremes +15 and -16
    curReq = "R2";
    feed(100); feed(103); feed(95); feed(110); feed(94); feed(93);
    feed(78); feed(62);
    idle(3);

    // R4: 9,9,9,9 then 5
    curReq = "R4";
    feed(9); feed(9); feed(9); feed(9); feed(5); feed(6);
    idle(3);

    // R5: 1,2,3,4 then 20
    curReq = "R5";
    feed(1); feed(2); feed(3); feed(4); feed(20); feed(21);
    idle(3);

    // R10: step run broken by a repeat
    curReq = "R10";
    feed(10); feed(12); feed(14); feed(16); feed(16); feed(16); feed(3);
    idle(3);

    // R6: back-to-back breaks through the holding slot
    curReq = "R6";
    feed(5); feed(5); feed(50); feed(50); feed(80); feed(81); feed(200);
    feed(200); feed(200); feed(7); feed(9); feed(11); feed(130);
    idle(3);

    // R7: long repeat run past 255, then a long step run
    curReq = "R7";
    for (int i = 0; i < 600; i++) feed(7);
    feed(90);
    for (int i = 0; i < 300; i++) feed((91 + 3 * i) & 255);
    feed(0);
    idle(3);

    // R8: enable drops mid-run and right after a break
    curReq = "R8";
    feed(40); feed(40); feed(40); idle(4);
    feed(1); feed(2); feed(3); feed(3); feed(60); idle(4);
    feed(8); feed(9); idle(1); feed(9); feed(9); idle(3);

    // R9: reset in the middle of a run
    curReq = "R9";
    feed(33); feed(33); feed(33);
    step(1, 0, 0); step(1, 1, 33);
    feed(33); feed(34);
    idle(3);

    // R6: random mix with enable dropouts
    curReq = "R6";
    cur = 0; dl = 1;
    for (int i = 0; i < 4000; i++) begin
      sel = $urandom_range(0, 99);
      if (sel < 3) begin
        idle($urandom_range(1, 3));
      end else begin
        if (sel < 40) ;
        else if (sel < 65) cur = (cur + dl) & 255;
        else if (sel < 85) begin
          dl = $urandom_range(0, 31) - 16;
          cur = (cur + dl) & 255;
        end else begin
          dl = $urandom_range(0, 255);
          cur = (cur + dl) & 255;
        end
        feed(cur);
      end
    end
    idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule